// File: doc/BRIEF.md
# Byte-Level I2C Bus Master with Register Interface

This block is an I2C master that a host controls through five byte-wide registers on a simple synchronous write/read port. The host loads a 16-bit clock divider, turns the core on, places an address or data byte in the data register, and then writes one command byte. That one command can run a START condition, eight data bits with their acknowledge slot, and a STOP condition in sequence. When the operation ends, the block sets an interrupt flag. The flag raises the interrupt output if the host has enabled it.

The block drives the two open-drain lines through active-high pull-low enables and samples both lines back through an input register stage. It uses the sampled lines in three ways. It tracks whether the bus is busy from START and STOP conditions made by any master. It takes the acknowledge bit from the slave. It detects loss of arbitration when another device holds SDA low while this master leaves it released. Reads on the register port are combinational, and writes take effect on the clock edge.

Top module: `i2c_byte_master`

## Requirements
- R1: Offsets 0 and 1 hold the low and high bytes of the divider, which resets to 0xFFFF. Offset 2 holds the control bits, which reset to 0 and read back in bits 7:6. Offset 3 is the data register. A read of offset 4 returns status, whose reset value is 0x00.
- R2: Control bit 7 turns the core on. While it is 0, both line enables are 0 from the next cycle on, and a command write leaves transfer-in-progress (status bit 1) at 0.
- R3: A command with bit 7 (start) and bit 4 (write) set drives a START condition and then shifts the data register out MSB first. Status bit 1 reads 1 from the cycle after the command write until the acknowledge slot ends.
- R4: After a write, status bit 7 holds the sampled acknowledge slot: 0 when the slave pulled SDA low and 1 when it did not.
- R5: A command with bit 5 (read) clocks in eight bits MSB first and puts the byte in the data register. In the acknowledge slot the master pulls SDA low when command bit 3 is 0 and releases SDA when command bit 3 is 1.
- R6: Command bit 6 (stop) drives a STOP condition after any byte phase in the same command. A command of 0x41 produces only the STOP.
- R7: Every finished or aborted operation sets status bit 0. A command write with bit 0 set clears it. The interrupt output equals status bit 0 AND control bit 6.
- R8: Status bit 6 becomes 1 when a START is seen on the lines (SDA falls while SCL is high). It becomes 0 when a STOP is seen (SDA rises while SCL is high). The bit changes on the second clock edge after the line change.
- R9: If SDA samples low while the master sends a 1 in a write bit, the master sets status bit 5, releases both lines, ends the operation and sets status bit 0. The next accepted command clears status bit 5.
- R10: Each bit, START and STOP lasts five divider ticks of (divider+1) clocks each. While a command runs, the time between consecutive SCL rising edges is 5*(divider+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset, 0 to 4 |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions run on every cycle and check these cycle-level rules:
- An accepted command makes the transfer bit 1 on the next cycle.
- Disabling the core releases both lines.
- A seen START sets the busy bit.
- A rise of the interrupt flag always follows an active operation.
- Arbitration loss ends the operation and releases the lines in the same step.

The bench watches the lines with its own reference model of bus activity and compares the busy bit and the release rule on every clock. Only its scenarios can show the bit order on the wire, the acknowledge exchange with a modelled slave, the received data, repeated starts, the SCL period and the abort under a competing master.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter logic [15:0] DIV_RST = 16'hFFFF
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [2:0] A_DIVL = 3'd0, A_DIVH = 3'd1, A_CTRL = 3'd2, A_DATA = 3'd3, A_CMD = 3'd4;
  localparam logic [2:0] PH_SMP = 3'd2, PH_END = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} st_t;

  st_t         st;
  logic [15:0] div, cnt;
  logic        en, ien;
  logic [7:0]  dat, sh;
  logic [2:0]  ph, bitn;
  logic        c_sto, c_rd, c_wr, c_nack;
  logic        sif, sal, rxack, busy;
  logic        scl_q, sda_q, sda_d;
  logic        hold_scl, hold_sda;
  logic        lv_scl, lv_sda, bitv;

  wire tip       = (st != S_IDLE);
  wire wr_cmd    = reg_we && (reg_addr == A_CMD);
  wire accept    = wr_cmd && en && !tip && (|reg_wdata[7:4]);
  wire tick      = tip && (cnt == 16'd0);
  wire last      = (ph == PH_END);
  wire smp       = (ph == PH_SMP);
  wire start_det = scl_q && sda_d && !sda_q;
  wire stop_det  = scl_q && !sda_d && sda_q;
  wire lost      = smp && (st == S_BIT) && c_wr && sh[7] && !sda_q;

  assign bitv = (st == S_BIT) ? (c_wr ? sh[7] : 1'b1) : (c_wr ? 1'b1 : c_nack);

  always_comb begin
    lv_scl = hold_scl;
    lv_sda = hold_sda;
    case (st)
      S_START: case (ph)
        3'd0:       begin lv_scl = 1'b0; lv_sda = 1'b1; end
        3'd1:       begin lv_scl = 1'b1; lv_sda = 1'b1; end
        3'd2, 3'd3: begin lv_scl = 1'b1; lv_sda = 1'b0; end
        default:    begin lv_scl = 1'b0; lv_sda = 1'b0; end
      endcase
      S_STOP: case (ph)
        3'd0:       begin lv_scl = 1'b0; lv_sda = 1'b0; end
        3'd1, 3'd2: begin lv_scl = 1'b1; lv_sda = 1'b0; end
        default:    begin lv_scl = 1'b1; lv_sda = 1'b1; end
      endcase
      S_BIT, S_ACK: begin
        lv_scl = !(ph == 3'd0 || ph == PH_END);
        lv_sda = bitv;
      end
      default: ;
    endcase
  end

  assign scl_oe = !(tip ? lv_scl : hold_scl);
  assign sda_oe = !(tip ? lv_sda : hold_sda);
  assign irq    = ien && sif;

  always_comb begin
    case (reg_addr)
      A_DIVL:  reg_rdata = div[7:0];
      A_DIVH:  reg_rdata = div[15:8];
      A_CTRL:  reg_rdata = {en, ien, 6'b0};
      A_DATA:  reg_rdata = dat;
      A_CMD:   reg_rdata = {rxack, busy, sal, 3'b000, tip, sif};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= DIV_RST; cnt <= 16'd0; en <= 1'b0; ien <= 1'b0;
      dat <= 8'h00; sh <= 8'h00; ph <= 3'd0; bitn <= 3'd7;
      c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0; c_nack <= 1'b0;
      sif <= 1'b0; sal <= 1'b0; rxack <= 1'b0; busy <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
      hold_scl <= 1'b1; hold_sda <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      sda_d <= sda_q;
      if (start_det) busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;

      if (reg_we) begin
        case (reg_addr)
          A_DIVL: div[7:0]  <= reg_wdata;
          A_DIVH: div[15:8] <= reg_wdata;
          A_CTRL: begin en <= reg_wdata[7]; ien <= reg_wdata[6]; end
          A_DATA: dat <= reg_wdata;
          default: ;
        endcase
      end
      if (wr_cmd && reg_wdata[0]) sif <= 1'b0;

      if (!en || accept || cnt == 16'd0) cnt <= div;
      else cnt <= cnt - 16'd1;

      if (!en) begin
        st <= S_IDLE;
        hold_scl <= 1'b1;
        hold_sda <= 1'b1;
      end else if (accept) begin
        sal    <= 1'b0;
        c_sto  <= reg_wdata[6];
        c_rd   <= reg_wdata[5];
        c_wr   <= reg_wdata[4];
        c_nack <= reg_wdata[3];
        sh     <= dat;
        ph     <= 3'd0;
        bitn   <= 3'd7;
        st     <= reg_wdata[7] ? S_START : ((reg_wdata[5] || reg_wdata[4]) ? S_BIT : S_STOP);
      end else if (tip) begin
        hold_scl <= lv_scl;
        hold_sda <= lv_sda;
        if (tick) begin
          ph <= last ? 3'd0 : ph + 3'd1;
          if (smp && st == S_BIT && !c_wr) sh <= {sh[6:0], sda_q};
          if (smp && st == S_ACK) begin
            if (c_wr) rxack <= sda_q;
            else dat <= sh;
          end
          if (lost) begin
            sal <= 1'b1;
            sif <= 1'b1;
            st  <= S_IDLE;
            hold_scl <= 1'b1;
            hold_sda <= 1'b1;
          end else if (last) begin
            case (st)
              S_START:
                if (c_rd || c_wr) st <= S_BIT;
                else if (c_sto) st <= S_STOP;
                else begin st <= S_IDLE; sif <= 1'b1; end
              S_BIT: begin
                if (c_wr) sh <= {sh[6:0], 1'b0};
                if (bitn == 3'd0) st <= S_ACK;
                else bitn <= bitn - 3'd1;
              end
              S_ACK:
                if (c_sto) st <= S_STOP;
                else begin st <= S_IDLE; sif <= 1'b1; end
              S_STOP: begin st <= S_IDLE; sif <= 1'b1; end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_accept_tip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tip) else $error("accepted command did not start");

  p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe)) else $error("lines held while core off");

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy) else $error("busy not set after start");

  p_if_after_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sif) |-> $past(tip)) else $error("flag rose without an operation");

  p_lost_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sal) |-> (!tip && !scl_oe && !sda_oe)) else $error("abort did not release lines");
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd4;
  logic [7:0] reg_wdata = 8'h00;
  logic reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 1'b0, force_low = 1'b0, nxt = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || slv_low || force_low);

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .irq(irq), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #2 clk = !clk;

  int total = 0, bad = 0, cyc = 0, off_cnt = 0;
  bit done_f = 0, m_en = 0, meas_on = 0, nack_mode = 0;
  logic ps = 1'b1, pd = 1'b1, m0 = 1'b0, d1 = 1'b0, d2 = 1'b0;
  bit s_act = 0, s_addr = 0, s_tx = 0, s_rd = 0, s_acked = 0, m_ack = 0;
  int s_cnt = 0, rx_n = 0, starts = 0, stops = 0;
  logic [7:0] s_sh = 8'h00, got = 8'h00, tx_b = 8'h00;
  logic [7:0] tx_q[$];
  int rise_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) slv_low <= nxt;

  always @(negedge clk) begin
    logic cs, cd;
    cs = scl_w;
    cd = sda_w;
    if (rst_n) begin
      if (cs && pd && !cd) m0 = 1'b1;
      else if (cs && !pd && cd) m0 = 1'b0;
      if (reg_addr == 3'd4 && !reg_we) chk(reg_rdata[6] == d2, "R8 busy model", reg_rdata[6], d2);
      d2 = d1;
      d1 = m0;
      off_cnt = m_en ? 0 : off_cnt + 1;
      if (off_cnt >= 3) chk(!scl_oe && !sda_oe, "R2 released while off", {scl_oe, sda_oe}, 0);
      if (meas_on && !ps && cs) rise_q.push_back(cyc);
    end
    if (ps && cs && pd && !cd) begin
      s_act = 1; s_cnt = 0; s_addr = 1; s_tx = 0; nxt = 1'b0; starts++;
    end else if (ps && cs && !pd && cd) begin
      s_act = 0; nxt = 1'b0; stops++;
    end else if (s_act) begin
      if (!ps && cs) begin
        if (s_cnt < 8) begin s_sh = {s_sh[6:0], cd}; s_cnt++; end
        else if (s_cnt == 8) begin if (s_tx) m_ack = cd; s_cnt = 9; end
      end else if (ps && !cs) begin
        if (s_cnt == 8) begin
          if (s_tx) nxt = 1'b0;
          else begin
            got = s_sh; rx_n++;
            if (s_addr) s_rd = s_sh[0];
            s_acked = !nack_mode && (!s_addr || s_sh[7:1] == 7'h52);
            nxt = s_acked;
          end
        end else if (s_cnt == 9) begin
          s_cnt = 0; nxt = 1'b0;
          if (s_addr) begin s_addr = 0; s_tx = s_rd && s_acked; end
          else if (s_tx && m_ack) s_tx = 0;
          if (s_tx) begin tx_b = tx_q.pop_front(); nxt = !tx_b[7]; end
        end else if (s_tx && s_cnt >= 1 && s_cnt <= 7) nxt = !tx_b[7 - s_cnt];
      end
    end
    ps = cs;
    pd = cd;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 3'd4;
    if (a == 3'd2) m_en = d[7];
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    @(posedge clk); #1;
    reg_addr = 3'd4;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (reg_addr == 3'd4 && !reg_rdata[1]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_f) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tx_q.push_back(8'h9B);
    tx_q.push_back(8'h4E);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(0, v); chk(v == 8'hFF, "R1 div low reset", v, 8'hFF);
    rd(1, v); chk(v == 8'hFF, "R1 div high reset", v, 8'hFF);
    rd(2, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    rd(4, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk(irq == 1'b0, "R7 irq reset", irq, 0);

    wr(0, 8'h03); wr(1, 8'h00);
    rd(0, v); chk(v == 8'h03, "R1 div low", v, 3);
    rd(1, v); chk(v == 8'h00, "R1 div high", v, 0);
    wr(3, 8'hA4);
    rd(3, v); chk(v == 8'hA4, "R1 data", v, 8'hA4);

    wr(4, 8'h91);
    rd(4, v); chk(v[1] == 1'b0, "R2 command ignored while off", v, 0);
    repeat (40) @(posedge clk);
    chk(starts == 0, "R2 no start while off", starts, 0);

    wr(2, 8'hC0);
    rd(2, v); chk(v == 8'hC0, "R1 ctrl readback", v, 8'hC0);

    rise_q.delete();
    meas_on = 1;
    wr(4, 8'h91);
    rd(4, v); chk(v[1] == 1'b1, "R3 tip while running", v, 2);
    wait_idle();
    meas_on = 0;
    chk(starts == 1, "R3 start seen", starts, 1);
    chk(got == 8'hA4, "R3 address byte MSB first", got, 8'hA4);
    rd(4, v); chk(v == 8'h41, "R4 ack status", v, 8'h41);
    chk(irq == 1'b1, "R7 irq raised", irq, 1);
    chk(rise_q.size() == 10, "R10 rise count", rise_q.size(), 10);
    if (rise_q.size() == 10) begin
      chk(rise_q[2] - rise_q[1] == 20, "R10 scl period", rise_q[2] - rise_q[1], 20);
      chk(rise_q[9] - rise_q[8] == 20, "R10 scl period ack", rise_q[9] - rise_q[8], 20);
    end
    wr(4, 8'h01);
    rd(4, v); chk(v == 8'h40, "R7 iack clears", v, 8'h40);
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);

    wr(3, 8'h3C); wr(4, 8'h10); wait_idle();
    chk(got == 8'h3C && rx_n == 2, "R3 data byte", got, 8'h3C);
    rd(4, v); chk(v[7] == 1'b0, "R4 ack on data", v, 0);

    nack_mode = 1;
    wr(3, 8'h55); wr(4, 8'h11); wait_idle();
    rd(4, v); chk(v == 8'hC1, "R4 nack status", v, 8'hC1);
    nack_mode = 0;

    wr(3, 8'hA5); wr(4, 8'h91); wait_idle();
    chk(starts == 2, "R5 repeated start", starts, 2);
    wr(4, 8'h21); wait_idle();
    rd(3, v); chk(v == 8'h9B, "R5 read byte", v, 8'h9B);
    chk(m_ack == 1'b0, "R5 master ack", m_ack, 0);
    wr(4, 8'h29); wait_idle();
    rd(3, v); chk(v == 8'h4E, "R5 read byte nack", v, 8'h4E);
    chk(m_ack == 1'b1, "R5 master nack", m_ack, 1);

    wr(4, 8'h41); wait_idle();
    chk(stops == 1, "R6 stop seen", stops, 1);
    rd(4, v); chk(v[6] == 1'b0 && v[0] == 1'b1, "R6 stop done idle", v, 8'h01);

    wr(2, 8'h80);
    wr(4, 8'h81); wait_idle();
    rd(4, v); chk(v[0] == 1'b1 && irq == 1'b0, "R7 irq masked", {v[0], irq}, 2);
    wr(4, 8'h41); wait_idle();
    chk(stops == 2, "R6 stop only", stops, 2);
    wr(2, 8'hC0);
    @(negedge clk); chk(irq == 1'b1, "R7 irq after enable", irq, 1);
    wr(4, 8'h01);

    wr(3, 8'hFF); wr(4, 8'h91);
    repeat (26) @(posedge clk);
    #1 force_low = 1'b1;
    wait_idle();
    rd(4, v); chk((v & 8'h23) == 8'h21, "R9 arbitration lost", v & 8'h23, 8'h21);
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    chk(irq == 1'b1, "R9 irq", irq, 1);
    @(posedge clk); #1 force_low = 1'b0;
    repeat (6) @(posedge clk);
    rd(4, v); chk(v[6] == 1'b0, "R8 busy cleared by stop", v, 0);
    wr(4, 8'h41); wait_idle();
    rd(4, v); chk(v[5] == 1'b0, "R9 lost cleared by new command", v, 0);

    wr(2, 8'h00);
    repeat (10) @(posedge clk);
    chk(!scl_oe && !sda_oe, "R2 disable releases", {scl_oe, sda_oe}, 0);

    done_f = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule